// File: doc/BRIEF.md
# Short Message Packet Formatter

This block carries tiny messages, such as acknowledgements, that software sends with one uncached store. A store that lands in the block's address window carries part of the message in its address: an 8-bit destination and 5 payload bits. The other 32 payload bits travel in the store data. The transmit half turns the store into a four-flit packet. The flits are a 16-bit header with the destination and the 5 address payload bits, the upper and lower halves of the data word, and a CRC-16 over the first three flits. The flits leave under valid/ready flow control. No buffer is shared through coherence, so no barrier or cache maintenance precedes a send.

The receive half takes four flits from the network. It recomputes the CRC and hands the message to the consumer as two 32-bit words. The first word holds the sender's node id and the 5-bit payload. The second word holds the 32-bit payload. A packet whose CRC does not match is dropped, and a saturating error counter records it. On arrival, the fabric has replaced the routing byte of the header with the sender's node id.

Top module: `smsg_fmt`

## Requirements
- R1: After reset, tx_valid_o and msg_valid_o are low, st_ready_o and rx_ready_o are high, and err_cnt_o is zero.
- R2: A store is in the window when st_addr_i[31:13] equals WIN_TAG. The destination is taken from st_addr_i[12:5] and the 5 address payload bits from st_addr_i[4:0].
- R3: A store accepted in the window produces exactly four flits, in this order. The header is {dest[7:0], pay5[4:0], 3'b000}. Then come st_data_i[31:16], st_data_i[15:0], and last the CRC flit.
- R4: The CRC is a 16-bit CRC with polynomial 0x1021 and initial value 0xFFFF. It is computed MSB first, with no reflection and no final XOR, over the header, the upper data flit and the lower data flit, in that order.
- R5: A store outside the window is accepted (st_ready_o high) and discarded, and no flit is emitted for it.
- R6: While tx_valid_o is high and tx_ready_i is low, the flit holds its value. st_ready_o stays low while a packet is being emitted.
- R7: A received packet with a correct CRC yields two words. Word 0 is {19'b0, hdr[15:8] source, hdr[7:3] payload} with msg_last_o low. Word 1 is {flit1, flit2} with msg_last_o high.
- R8: A received packet whose CRC flit differs from the computed CRC yields no words and adds one to err_cnt_o.
- R9: err_cnt_o saturates at 2^ERR_W-1 and never decreases.
- R10: rx_ready_o is low while received words are pending. msg_word_o and msg_last_o hold while msg_valid_o is high and msg_ready_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store accepted this cycle |
| st_addr_i | input | 32 | Store address: window tag, destination, 5 payload bits |
| st_data_i | input | 32 | Store data: 32 payload bits |
| tx_valid_o | output | 1 | Outgoing flit valid |
| tx_ready_i | input | 1 | Network takes outgoing flit |
| tx_flit_o | output | 16 | Outgoing flit |
| rx_valid_i | input | 1 | Incoming flit valid |
| rx_ready_o | output | 1 | Block takes incoming flit |
| rx_flit_i | input | 16 | Incoming flit |
| msg_valid_o | output | 1 | Received word valid |
| msg_ready_i | input | 1 | Consumer takes received word |
| msg_word_o | output | 32 | Received word |
| msg_last_o | output | 1 | High on the second (payload) word |
| err_cnt_o | output | ERR_W | Saturating count of CRC-failed packets |

## Verification
On every cycle, the assertions check several behaviours. Both outputs hold while the consumer stalls. An accepted store puts its destination into the next header. Received words appear only after an accepted CRC flit. The error counter never moves backwards and sticks at its maximum. Only the bench's scenarios can show that the flit order and the CRC value are right for many messages under backpressure. They also show that stores outside the window leave no trace, that corrupt packets are dropped while good ones around them pass, and that saturation is reached after many errors.

// File: rtl/smsg_pkg.sv
package smsg_pkg;
  localparam int FLIT_W  = 16;
  localparam int WORD_W  = 2 * FLIT_W;
  localparam int ADDR_W  = 32;
  localparam int DEST_W  = 8;
  localparam int PAY_W   = 5;
  localparam int HDR_PAD = FLIT_W - DEST_W - PAY_W;
  localparam int PAY_LSB  = 0;
  localparam int DEST_LSB = PAY_LSB + PAY_W;
  localparam int WIN_LSB  = DEST_LSB + DEST_W;
  localparam int WIN_W    = ADDR_W - WIN_LSB;
  localparam int W0_PAD   = WORD_W - DEST_W - PAY_W;

  localparam logic [FLIT_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [FLIT_W-1:0] CRC_INIT = 16'hFFFF;

  typedef logic [FLIT_W-1:0] flit_t;
  typedef logic [WORD_W-1:0] word_t;

  // position of a flit inside a packet
  typedef enum logic [1:0] {FL_HDR, FL_PHI, FL_PLO, FL_CRC} flit_idx_e;

  function automatic flit_t crc_step(flit_t crc_in, flit_t data);
    flit_t c;
    logic  fb;
    c = crc_in;
    for (int i = FLIT_W - 1; i >= 0; i--) begin
      fb = c[FLIT_W-1] ^ data[i];
      c  = {c[FLIT_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/smsg_tx.sv
module smsg_tx
  import smsg_pkg::*;
#(
  parameter int unsigned WIN_TAG = 'h31C5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  word_t             st_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output flit_t             tx_flit_o
);
  localparam int NFL = 4;

  logic      in_win, accept;
  flit_t     hdr_d, crc_d;
  flit_t     flit_q [NFL];
  flit_idx_e idx_q;
  logic      busy_q;

  assign in_win = st_addr_i[ADDR_W-1:WIN_LSB] == WIN_W'(WIN_TAG);
  assign st_ready_o = !busy_q;
  assign accept = st_valid_i && st_ready_o && in_win;

  assign hdr_d = {st_addr_i[DEST_LSB +: DEST_W], st_addr_i[PAY_LSB +: PAY_W], {HDR_PAD{1'b0}}};
  assign crc_d = crc_step(crc_step(crc_step(CRC_INIT, hdr_d),
                                   st_data_i[WORD_W-1:FLIT_W]),
                          st_data_i[FLIT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= FL_HDR;
      for (int i = 0; i < NFL; i++) flit_q[i] <= '0;
    end else if (accept) begin
      flit_q[FL_HDR] <= hdr_d;
      flit_q[FL_PHI] <= st_data_i[WORD_W-1:FLIT_W];
      flit_q[FL_PLO] <= st_data_i[FLIT_W-1:0];
      flit_q[FL_CRC] <= crc_d;
      busy_q <= 1'b1;
      idx_q  <= FL_HDR;
    end else if (busy_q && tx_ready_i) begin
      if (idx_q == FL_CRC) busy_q <= 1'b0;
      idx_q <= flit_idx_e'(idx_q + 2'd1);
    end
  end

  assign tx_valid_o = busy_q;
  assign tx_flit_o  = flit_q[idx_q];

  a_r6_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_flit_o)));

  a_r2_hdr_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (tx_valid_o &&
                tx_flit_o[FLIT_W-1 -: DEST_W] == $past(st_addr_i[DEST_LSB +: DEST_W])));
endmodule

// File: rtl/smsg_rx.sv
module smsg_rx
  import smsg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rx_valid_i,
  output logic  rx_ready_o,
  input  flit_t rx_flit_i,
  output logic  msg_valid_o,
  input  logic  msg_ready_i,
  output word_t msg_word_o,
  output logic  msg_last_o,
  output logic  crc_err_o
);
  flit_idx_e idx_q;
  flit_t     hdr_q, phi_q, plo_q, crc_q;
  word_t     w0_q, w1_q;
  logic      pend_q, sel_q;
  logic      take, crc_ok;

  assign rx_ready_o = !pend_q;
  assign take       = rx_valid_i && rx_ready_o;
  assign crc_ok     = rx_flit_i == crc_q;
  assign crc_err_o  = take && idx_q == FL_CRC && !crc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= FL_HDR;
      hdr_q <= '0;
      phi_q <= '0;
      plo_q <= '0;
      crc_q <= CRC_INIT;
    end else if (take) begin
      idx_q <= flit_idx_e'(idx_q + 2'd1);
      unique case (idx_q)
        FL_HDR: begin hdr_q <= rx_flit_i; crc_q <= crc_step(crc_q, rx_flit_i); end
        FL_PHI: begin phi_q <= rx_flit_i; crc_q <= crc_step(crc_q, rx_flit_i); end
        FL_PLO: begin plo_q <= rx_flit_i; crc_q <= crc_step(crc_q, rx_flit_i); end
        FL_CRC: crc_q <= CRC_INIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      sel_q  <= 1'b0;
      w0_q   <= '0;
      w1_q   <= '0;
    end else if (take && idx_q == FL_CRC && crc_ok) begin
      pend_q <= 1'b1;
      sel_q  <= 1'b0;
      w0_q   <= {{W0_PAD{1'b0}}, hdr_q[FLIT_W-1 -: DEST_W], hdr_q[HDR_PAD +: PAY_W]};
      w1_q   <= {phi_q, plo_q};
    end else if (pend_q && msg_ready_i) begin
      if (sel_q) pend_q <= 1'b0;
      sel_q <= !sel_q;
    end
  end

  assign msg_valid_o = pend_q;
  assign msg_word_o  = sel_q ? w1_q : w0_q;
  assign msg_last_o  = sel_q;

  a_r10_msg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_word_o) && $stable(msg_last_o)));

  a_r7_msg_after_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(rx_valid_i && rx_ready_o));

  a_r7_first_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> !msg_last_o);
endmodule

// File: rtl/smsg_sat_cnt.sv
module smsg_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  a_r9_err_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX) |=> (cnt_o == MAX));

  a_r9_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));

  a_r8_err_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_o != MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/smsg_fmt.sv
module smsg_fmt
  import smsg_pkg::*;
#(
  parameter int unsigned WIN_TAG = 'h31C5A,
  parameter int          ERR_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_valid_i,
  output logic             st_ready_o,
  input  logic [31:0]      st_addr_i,
  input  logic [31:0]      st_data_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [15:0]      tx_flit_o,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [15:0]      rx_flit_i,
  output logic             msg_valid_o,
  input  logic             msg_ready_i,
  output logic [31:0]      msg_word_o,
  output logic             msg_last_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  logic crc_err;

  smsg_tx #(.WIN_TAG(WIN_TAG)) i_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_valid_i (st_valid_i),
    .st_ready_o (st_ready_o),
    .st_addr_i  (st_addr_i),
    .st_data_i  (st_data_i),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_flit_o  (tx_flit_o)
  );

  smsg_rx i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_ready_o  (rx_ready_o),
    .rx_flit_i   (rx_flit_i),
    .msg_valid_o (msg_valid_o),
    .msg_ready_i (msg_ready_i),
    .msg_word_o  (msg_word_o),
    .msg_last_o  (msg_last_o),
    .crc_err_o   (crc_err)
  );

  smsg_sat_cnt #(.W(ERR_W)) i_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (crc_err),
    .cnt_o  (err_cnt_o)
  );
endmodule

// File: tb/test_smsg_fmt.sv
`timescale 1ns/1ps
module test_smsg_fmt;
  localparam int          ERR_W = 8;
  localparam logic [18:0] WIN   = 19'h31C5A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_valid_i = 1'b0;
  logic        st_ready_o;
  logic [31:0] st_addr_i = '0;
  logic [31:0] st_data_i = '0;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b1;
  logic [15:0] tx_flit_o;
  logic        rx_valid_i = 1'b0;
  logic        rx_ready_o;
  logic [15:0] rx_flit_i = '0;
  logic        msg_valid_o;
  logic        msg_ready_i = 1'b1;
  logic [31:0] msg_word_o;
  logic        msg_last_o;
  logic [ERR_W-1:0] err_cnt_o;

  int checks = 0;
  int fails  = 0;
  int err_exp = 0;
  bit bp_tx = 0, bp_rx = 0;
  int unsigned cyc = 0;

  logic [15:0] txq[$];
  string       txr[$];
  logic [32:0] rxq[$];

  always #2 clk_i = ~clk_i;

  smsg_fmt #(.WIN_TAG(32'h31C5A), .ERR_W(ERR_W)) i_smsg_fmt (.*);

  function automatic logic [15:0] ref_crc(logic [47:0] bits);
    logic [15:0] r = 16'hFFFF;
    for (int k = 47; k >= 0; k--) begin
      if (r[15] ^ bits[k]) r = (r << 1) ^ 16'h1021;
      else                 r = r << 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // backpressure patterns
  initial forever begin
    @(posedge clk_i); #1;
    cyc++;
    tx_ready_i  = !bp_tx || (cyc % 3 != 0);
    msg_ready_i = !bp_rx || (cyc[0] ^ cyc[2]);
  end

  task automatic drive_store(input logic [31:0] a, input logic [31:0] d);
    bit acc;
    logic [15:0] h;
    if (a[31:13] == WIN) begin
      h = {a[12:5], a[4:0], 3'b000};
      txq.push_back(h);            txr.push_back("R2/R3 header");
      txq.push_back(d[31:16]);     txr.push_back("R3 payload high");
      txq.push_back(d[15:0]);      txr.push_back("R3 payload low");
      txq.push_back(ref_crc({h, d})); txr.push_back("R4 crc");
    end
    st_addr_i = a; st_data_i = d; st_valid_i = 1'b1;
    do begin @(negedge clk_i); acc = st_ready_o; @(posedge clk_i); #1; end while (!acc);
    st_valid_i = 1'b0;
  endtask

  task automatic drive_pkt(input logic [7:0] src, input logic [4:0] p5, input logic [31:0] d, input bit bad);
    logic [15:0] fl[4];
    bit acc;
    fl[0] = {src, p5, 3'b000};
    fl[1] = d[31:16];
    fl[2] = d[15:0];
    fl[3] = ref_crc({fl[0], d}) ^ (bad ? 16'h0001 : 16'h0000);
    if (!bad) begin
      rxq.push_back({1'b0, 19'b0, src, p5});
      rxq.push_back({1'b1, d});
    end else if (err_exp < (1 << ERR_W) - 1) err_exp++;
    for (int k = 0; k < 4; k++) begin
      rx_flit_i = fl[k]; rx_valid_i = 1'b1;
      do begin @(negedge clk_i); acc = rx_ready_o; @(posedge clk_i); #1; end while (!acc);
    end
    rx_valid_i = 1'b0;
  endtask

  // tx scoreboard monitor
  bit tx_stall = 0; logic [15:0] tx_prev;
  bit rx_stall = 0; logic [32:0] rx_prev;
  initial forever begin
    @(negedge clk_i);
    if (rst_ni) begin
      if (tx_stall) check(tx_valid_o && tx_flit_o == tx_prev, "R6 hold", {16'b0, tx_flit_o}, {16'b0, tx_prev});
      if (tx_valid_o) check(!st_ready_o, "R6 st_ready low", {31'b0, st_ready_o}, 32'd0);
      if (tx_valid_o && tx_ready_i) begin
        if (txq.size() == 0) check(1'b0, "R5 unexpected flit", {16'b0, tx_flit_o}, 32'hx);
        else begin
          logic [15:0] e; string r;
          e = txq.pop_front(); r = txr.pop_front();
          check(tx_flit_o == e, r, {16'b0, tx_flit_o}, {16'b0, e});
        end
      end
      tx_stall = tx_valid_o && !tx_ready_i; tx_prev = tx_flit_o;

      if (rx_stall) check(msg_valid_o && {msg_last_o, msg_word_o} == rx_prev, "R10 hold",
                          msg_word_o, rx_prev[31:0]);
      if (msg_valid_o) check(!rx_ready_o, "R10 rx_ready low", {31'b0, rx_ready_o}, 32'd0);
      if (msg_valid_o && msg_ready_i) begin
        if (rxq.size() == 0) check(1'b0, "R8 unexpected word", msg_word_o, 32'hx);
        else begin
          logic [32:0] e;
          e = rxq.pop_front();
          check({msg_last_o, msg_word_o} == e, "R7 word", msg_word_o, e[31:0]);
        end
      end
      rx_stall = msg_valid_o && !msg_ready_i; rx_prev = {msg_last_o, msg_word_o};
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!tx_valid_o && !msg_valid_o, "R1 valids", {30'b0, tx_valid_o, msg_valid_o}, 32'd0);
    check(st_ready_o && rx_ready_o, "R1 readies", {30'b0, st_ready_o, rx_ready_o}, 32'd3);
    check(err_cnt_o == 0, "R1 err", {24'b0, err_cnt_o}, 32'd0);
    @(posedge clk_i); #1; rst_ni = 1'b1;
    repeat (2) @(posedge clk_i); #1;

    // R2 R3 R4 transmit without and with backpressure
    drive_store({WIN, 8'h00, 5'h00}, 32'h0000_0000);
    drive_store({WIN, 8'hFF, 5'h1F}, 32'hFFFF_FFFF);
    drive_store({WIN, 8'hA5, 5'h0C}, 32'h1234_5678);
    bp_tx = 1;
    for (int i = 0; i < 6; i++)
      drive_store({WIN, 8'(i * 37 + 3), 5'(i * 7)}, 32'hDEAD_0000 + 32'(i * 4099));
    while (txq.size() != 0) @(posedge clk_i);
    #1;

    // R5 outside window: no flit, accepted
    drive_store({WIN ^ 19'h00001, 8'h44, 5'h05}, 32'hCAFE_BABE);
    drive_store({19'h00000, 8'h12, 5'h1A}, 32'h0BAD_F00D);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check(!tx_valid_o, "R5 no flit", {31'b0, tx_valid_o}, 32'd0);
    end
    bp_tx = 0;

    // R7 receive, R8 drop, R10 backpressure
    @(posedge clk_i); #1;
    drive_pkt(8'h3C, 5'h11, 32'h89AB_CDEF, 0);
    drive_pkt(8'h01, 5'h02, 32'h0000_0001, 1);
    check(err_cnt_o == ERR_W'(err_exp), "R8 err count", {24'b0, err_cnt_o}, err_exp);
    drive_pkt(8'hFE, 5'h1F, 32'h7FFF_8000, 0);
    bp_rx = 1;
    for (int i = 0; i < 6; i++) begin
      drive_pkt(8'(i * 29), 5'(i + 9), 32'h5A5A_0000 ^ 32'(i * 771), (i == 3));
      if (i == 3) check(err_cnt_o == ERR_W'(err_exp), "R8 err after bad", {24'b0, err_cnt_o}, err_exp);
    end
    while (rxq.size() != 0) @(posedge clk_i);
    #1;
    bp_rx = 0;

    // R9 saturation
    for (int i = 0; i < 260; i++) drive_pkt(8'h77, 5'h03, 32'(i), 1);
    check(err_cnt_o == '1, "R9 saturated", {24'b0, err_cnt_o}, 32'hFF);
    drive_pkt(8'h42, 5'h15, 32'hC001_D00D, 0);
    while (rxq.size() != 0) @(posedge clk_i);
    repeat (2) @(negedge clk_i);
    check(err_cnt_o == '1, "R9 stays", {24'b0, err_cnt_o}, 32'hFF);
    check(txq.size() == 0 && rxq.size() == 0, "R3 R7 drained", txq.size() + rxq.size(), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule